// File: doc/BRIEF.md
# Mailbox Command Sequencer

The block sends one command of a fixed five-word format to a coprocessor and collects the reply. The command frame is a header, the command code, an argument count, one argument and an additive checksum. After a start, the engine writes the frame into the shared message area, rings the coprocessor's doorbell, and polls the reply mailbox at a fixed spacing. It stops polling when the mailbox reads nonzero or the attempt limit is reached. On a reply it reads the five reply words back and checks their checksum. On every completed exchange it writes zero to the reply mailbox, then reports a one-hot result code and the returned argument word.

The bus side is a single-outstanding request/acknowledge master with byte addresses and 32-bit data. The poll spacing (in clock cycles) and the attempt limit are parameters, so that a simulation can use small values while the defaults match a 5 µs spacing and a 200000-attempt limit at 125 MHz.

Top module: `mbox_cmd_seq`

## Requirements
- R1: After reset `done_o`, `status_o`, `arg_o` and `bus_req_o` are all zero.
- R2: For a valid select the engine writes five words to byte addresses 0x100, 0x104, 0x108, 0x10C and 0x110, in that order. The words are header 1, a command word, argument count 1, an argument word, and a checksum. Select 0 sends command 1 with argument 1 and checksum 4. Select 1 sends command 2 with argument 1 and checksum 5. Select 2 sends command 2 with argument 2 and checksum 6.
- R3: A reply whose checksum word (reply word 4) differs from the 32-bit wrapping sum of reply words 0 to 3 yields status 5'b00100, whatever the mailbox code was.
- R4: After the fifth frame word, and before any poll, the value 1 is written once to the doorbell at byte address 0x10.
- R5: The reply mailbox at byte address 0x14 is read until it returns nonzero. Between the acknowledge of one poll and the request of the next there are exactly POLL_GAP cycles with no request.
- R6: After POLL_LIMIT polls that all read zero, the result is status 5'b10000 (timeout) and `arg_o` is 0, and no reply word is read.
- R7: A mailbox code of exactly 1 with a correct reply checksum yields status 0, and `arg_o` equals reply word 3.
- R8: Any other mailbox code with a correct checksum maps to a one-hot status from the lowest set bit among code bits 0 to 2. Bit 0 gives 5'b00001 (bad header), bit 1 gives 5'b00010 (invalid command or argument), and bit 2 gives 5'b00100 (bad checksum). Otherwise the status is 5'b01000 (malformed). Bit 31 is the error flag and does not take part in the mapping. `status_o` is never more than one-hot.
- R9: On success, error reply and timeout alike, exactly one write of 0 to byte address 0x14 completes before `done_o` rises.
- R10: A start with select 3 raises `done_o` in the next cycle with status 5'b00010, and makes no bus request.
- R11: `done_o` is a one-cycle pulse. A start while a command is in flight is ignored. `status_o` and `arg_o` change only in the cycle `done_o` is high.
- R12: While `bus_req_o` is high and not yet acknowledged, the request, address, write flag and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| cmd_sel_i | input | 2 | Command select (0 to 2 valid) |
| bus_req_o | output | 1 | Bus request, held until acknowledged |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Byte address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Acknowledge, one cycle per access |
| bus_rdata_i | input | 32 | Read data, valid with the acknowledge |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 5 | One-hot result code, 0 = success |
| arg_o | output | 32 | Returned argument word |

## Verification
The bench attacks the reply checksum with a wrapping argument and with a corrupted checksum word under an error code, because a design that skipped the override or summed without wrap would report the wrong status. It feeds codes with several error bits, and one with only the flag bit, so that a wrong priority or a missing malformed fallback shows up as the wrong one-hot value. A reply that never comes must end after exactly the set number of polls, with no reply reads and with the mailbox cleared. The bench also checks that a second start while busy does not change the frame that was sent, and that a select of 3 finishes at once with no bus traffic.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  localparam int WORD_W    = 32;
  localparam int FRAME_LEN = 5;
  localparam int NUM_CMD   = 3;

  // byte offsets in the coprocessor register space
  localparam logic [31:0] MSG_BASE    = 32'h100;
  localparam logic [31:0] DOORBELL    = 32'h10;
  localparam logic [31:0] REPLY_MBOX  = 32'h14;

  typedef logic [1:0]        cmd_sel_t;
  typedef logic [WORD_W-1:0] word_t;

  // one-hot result codes
  localparam logic [4:0] ST_OK    = 5'b00000;
  localparam logic [4:0] ST_HDR   = 5'b00001;
  localparam logic [4:0] ST_INVAL = 5'b00010;
  localparam logic [4:0] ST_CKSUM = 5'b00100;
  localparam logic [4:0] ST_MALF  = 5'b01000;
  localparam logic [4:0] ST_TMO   = 5'b10000;

  typedef enum logic [2:0] {
    S_IDLE, S_SEND, S_BELL, S_POLL, S_GAP, S_FETCH, S_CLEAR, S_FIN
  } seq_state_t;

  function automatic word_t sum4(word_t a, word_t b, word_t c, word_t d);
    return a + b + c + d;
  endfunction

  // word k of the outgoing frame for a given select
  function automatic word_t frame_word(cmd_sel_t sel, logic [2:0] k);
    word_t hdr, cmd, cnt, arg;
    hdr = 32'd1;
    cnt = 32'd1;
    cmd = (sel == 2'd0) ? 32'd1 : 32'd2;
    arg = (sel == 2'd2) ? 32'd2 : 32'd1;
    case (k)
      3'd0:    return hdr;
      3'd1:    return cmd;
      3'd2:    return cnt;
      3'd3:    return arg;
      default: return sum4(hdr, cmd, cnt, arg);
    endcase
  endfunction

  // reply code plus checksum verdict to one-hot result
  function automatic logic [4:0] map_reply(word_t code, logic sum_ok);
    if (!sum_ok)          return ST_CKSUM;
    else if (code == 32'd1) return ST_OK;
    else if (code[0])     return ST_HDR;
    else if (code[1])     return ST_INVAL;
    else if (code[2])     return ST_CKSUM;
    else                  return ST_MALF;
  endfunction
endpackage

// File: rtl/mbox_frame_gen.sv
`timescale 1ns/1ps
module mbox_frame_gen
  import mbox_pkg::*;
(
  input  cmd_sel_t   sel_i,
  input  logic [2:0] idx_i,
  output word_t      word_o
);
  assign word_o = frame_word(sel_i, idx_i);
endmodule

// File: rtl/mbox_poll_timer.sv
`timescale 1ns/1ps
module mbox_poll_timer #(
  parameter int POLL_GAP   = 625,
  parameter int POLL_LIMIT = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic miss_i,
  output logic exhausted_o,
  output logic wait_over_o
);
  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam int ATT_W = $clog2(POLL_LIMIT + 1);

  logic [GAP_W-1:0] gap_q;
  logic [ATT_W-1:0] att_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      att_q <= '0;
    end else if (arm_i) begin
      gap_q <= '0;
      att_q <= '0;
    end else if (miss_i) begin
      att_q <= att_q + 1'b1;
      gap_q <= GAP_W'(POLL_GAP - 1);
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign exhausted_o = (att_q == ATT_W'(POLL_LIMIT));
  assign wait_over_o = (gap_q == '0);

  AST_ATTEMPT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    att_q <= ATT_W'(POLL_LIMIT)); // R6
  AST_NO_MISS_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted_o |-> !miss_i); // R6
endmodule

// File: rtl/mbox_reply_chk.sv
`timescale 1ns/1ps
module mbox_reply_chk
  import mbox_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       cap_i,
  input  logic [2:0] idx_i,
  input  word_t      word_i,
  output logic       sum_ok_o,
  output word_t      arg_o
);
  word_t sum_q, ck_q, arg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      ck_q  <= '0;
      arg_q <= '0;
    end else if (clear_i) begin
      sum_q <= '0;
      ck_q  <= '0;
      arg_q <= '0;
    end else if (cap_i) begin
      if (idx_i < 3'(FRAME_LEN - 1)) sum_q <= sum_q + word_i;
      if (idx_i == 3'd3)             arg_q <= word_i;
      if (idx_i == 3'(FRAME_LEN - 1)) ck_q <= word_i;
    end
  end

  assign sum_ok_o = (sum_q == ck_q);
  assign arg_o    = arg_q;
endmodule

// File: rtl/mbox_cmd_seq.sv
`timescale 1ns/1ps
module mbox_cmd_seq
  import mbox_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int POLL_GAP   = 625,
  parameter int POLL_LIMIT = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        cmd_sel_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [31:0]       bus_rdata_i,
  output logic              done_o,
  output logic [4:0]        status_o,
  output logic [31:0]       arg_o
);
  localparam logic [2:0] LAST_IDX = 3'(FRAME_LEN - 1);

  seq_state_t state_q;
  cmd_sel_t   sel_q;
  logic [2:0] idx_q;
  word_t      code_q, frame_w, chk_arg;
  logic       tmo_q, rejected_q, clr_seen_q, done_q, sum_ok;
  logic [4:0] status_q;
  word_t      arg_q;

  // named internal events
  logic launch_ok, launch_bad, bell_ack, poll_miss, poll_hit, fetch_ack, clear_ack;
  assign launch_ok  = (state_q == S_IDLE) && start_i && (cmd_sel_i < 2'(NUM_CMD));
  assign launch_bad = (state_q == S_IDLE) && start_i && !(cmd_sel_i < 2'(NUM_CMD));
  assign bell_ack   = (state_q == S_BELL)  && bus_ack_i;
  assign poll_hit   = (state_q == S_POLL)  && bus_ack_i && (bus_rdata_i != '0);
  assign poll_miss  = (state_q == S_POLL)  && bus_ack_i && (bus_rdata_i == '0);
  assign fetch_ack  = (state_q == S_FETCH) && bus_ack_i;
  assign clear_ack  = (state_q == S_CLEAR) && bus_ack_i;

  logic exhausted, wait_over;

  mbox_frame_gen u_frame (.sel_i(sel_q), .idx_i(idx_q), .word_o(frame_w));

  mbox_poll_timer #(.POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm_i(bell_ack), .miss_i(poll_miss),
    .exhausted_o(exhausted), .wait_over_o(wait_over)
  );

  mbox_reply_chk u_chk (
    .clk(clk), .rst_n(rst_n), .clear_i(launch_ok), .cap_i(fetch_ack),
    .idx_i(idx_q), .word_i(bus_rdata_i), .sum_ok_o(sum_ok), .arg_o(chk_arg)
  );

  // bus drive, a function of state only
  always_comb begin
    bus_req_o   = 1'b0;
    bus_we_o    = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    case (state_q)
      S_SEND: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = ADDR_W'(MSG_BASE) + ADDR_W'({idx_q, 2'b00});
        bus_wdata_o = frame_w;
      end
      S_BELL: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = ADDR_W'(DOORBELL);
        bus_wdata_o = 32'd1;
      end
      S_POLL: begin
        bus_req_o  = 1'b1;
        bus_addr_o = ADDR_W'(REPLY_MBOX);
      end
      S_FETCH: begin
        bus_req_o  = 1'b1;
        bus_addr_o = ADDR_W'(MSG_BASE) + ADDR_W'({idx_q, 2'b00});
      end
      S_CLEAR: begin
        bus_req_o  = 1'b1;
        bus_we_o   = 1'b1;
        bus_addr_o = ADDR_W'(REPLY_MBOX);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      sel_q      <= '0;
      idx_q      <= '0;
      code_q     <= '0;
      tmo_q      <= 1'b0;
      rejected_q <= 1'b0;
      clr_seen_q <= 1'b0;
      done_q     <= 1'b0;
      status_q   <= ST_OK;
      arg_q      <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (launch_bad) begin
            done_q     <= 1'b1;
            status_q   <= ST_INVAL;
            arg_q      <= '0;
            rejected_q <= 1'b1;
          end else if (launch_ok) begin
            sel_q      <= cmd_sel_i;
            idx_q      <= '0;
            tmo_q      <= 1'b0;
            rejected_q <= 1'b0;
            clr_seen_q <= 1'b0;
            state_q    <= S_SEND;
          end
        end
        S_SEND: if (bus_ack_i) begin
          if (idx_q == LAST_IDX) state_q <= S_BELL;
          else                   idx_q   <= idx_q + 1'b1;
        end
        S_BELL: if (bell_ack) state_q <= S_POLL;
        S_POLL: begin
          if (poll_hit) begin
            code_q  <= bus_rdata_i;
            idx_q   <= '0;
            state_q <= S_FETCH;
          end else if (poll_miss) begin
            state_q <= S_GAP;
          end
        end
        S_GAP: begin
          if (exhausted) begin
            tmo_q   <= 1'b1;
            state_q <= S_CLEAR;
          end else if (wait_over) begin
            state_q <= S_POLL;
          end
        end
        S_FETCH: if (fetch_ack) begin
          if (idx_q == LAST_IDX) state_q <= S_CLEAR;
          else                   idx_q   <= idx_q + 1'b1;
        end
        S_CLEAR: if (clear_ack) begin
          clr_seen_q <= 1'b1;
          state_q    <= S_FIN;
        end
        S_FIN: begin
          done_q   <= 1'b1;
          status_q <= tmo_q ? ST_TMO : map_reply(code_q, sum_ok);
          arg_q    <= tmo_q ? '0 : chk_arg;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign status_o = status_q;
  assign arg_o    = arg_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(status_o) && $stable(arg_o)); // R11
  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_o)); // R8
  AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !rejected_q |-> clr_seen_q); // R9
  AST_TMO_NO_ARG: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && status_o == ST_TMO |-> arg_o == '0); // R6
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    launch_bad |=> done_o && !bus_req_o); // R10
endmodule

// File: tb/mbox_cmd_seq_bench.sv
`timescale 1ns/1ps
module mbox_cmd_seq_bench;
  localparam int ADDR_W = 16;
  localparam int GAP    = 3;
  localparam int LIMIT  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] sel = 2'd0;
  logic bus_req, bus_we, ack, done;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0] bus_wdata, rdata, arg;
  logic [4:0] status;

  always #4 clk = ~clk;

  mbox_cmd_seq #(.ADDR_W(ADDR_W), .POLL_GAP(GAP), .POLL_LIMIT(LIMIT)) u_mbox_cmd_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_sel_i(sel),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_ack_i(ack), .bus_rdata_i(rdata),
    .done_o(done), .status_o(status), .arg_o(arg)
  );

  // responder configuration, driven only by the initial block
  logic [7:0]  cfg_after = 8'd1;
  logic [1:0]  cfg_lat   = 2'd0;
  logic        cfg_bad   = 1'b0;
  logic [31:0] cfg_code  = 32'd1;
  logic [31:0] cfg_arg   = 32'd0;
  logic        clr_stats = 1'b0;

  // responder state and statistics
  logic [31:0] sent [5];
  logic [31:0] rep  [5];
  logic [31:0] bell_val, host_last;
  int cyc = 0, wr_cnt, bell_pos, bell_cnt, host_wr, polls, msg_rd, acc_cnt, done_cnt;
  int last_t, prev_t, hold_err, wcnt, a;
  logic pw, pwe;
  logic [ADDR_W-1:0] pa;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      ack <= 1'b0; rdata <= '0; wcnt <= 0; pw <= 1'b0;
    end else begin
      ack <= 1'b0;
      if (pw && !(bus_req && bus_addr == pa && bus_we == pwe)) hold_err <= hold_err + 1;
      pw  <= bus_req && !ack;
      pa  <= bus_addr;
      pwe <= bus_we;
      if (bus_req && !ack) begin
        if (wcnt != int'(cfg_lat)) wcnt <= wcnt + 1;
        else begin
          wcnt <= 0;
          ack <= 1'b1;
          acc_cnt <= acc_cnt + 1;
          a = int'(bus_addr);
          if (bus_we) begin
            if (a >= 'h100 && a < 'h114) begin
              sent[(a - 'h100) / 4] <= bus_wdata;
              wr_cnt <= wr_cnt + 1;
            end else if (a == 'h10) begin
              bell_val <= bus_wdata; bell_pos <= wr_cnt; bell_cnt <= bell_cnt + 1; polls <= 0;
              rep[0] <= 32'd2; rep[1] <= 32'd7; rep[2] <= 32'd1; rep[3] <= cfg_arg;
              rep[4] <= 32'd10 + cfg_arg + {31'd0, cfg_bad};
            end else if (a == 'h14) begin
              host_wr <= host_wr + 1; host_last <= bus_wdata;
            end
          end else begin
            if (a == 'h14) begin
              polls <= polls + 1; prev_t <= last_t; last_t <= cyc;
              rdata <= (cfg_after != 0 && polls + 1 >= int'(cfg_after)) ? cfg_code : 32'd0;
            end else if (a >= 'h100 && a < 'h114) begin
              msg_rd <= msg_rd + 1; rdata <= rep[(a - 'h100) / 4];
            end else rdata <= '0;
          end
        end
      end
    end
    if (done) done_cnt <= done_cnt + 1;
    if (clr_stats) begin
      wr_cnt <= 0; bell_pos <= -1; bell_cnt <= 0; host_wr <= 0; host_last <= 32'hdead;
      polls <= 0; msg_rd <= 0; acc_cnt <= 0; done_cnt <= 0; hold_err <= 0;
      last_t <= 0; prev_t <= 0; bell_val <= 0;
      for (int k = 0; k < 5; k++) sent[k] <= 32'hffff_ffff;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int s, input int k);
    int cmdw = (s == 0) ? 1 : 2;
    int argw = (s == 2) ? 2 : 1;
    case (k)
      0: return 32'd1;
      1: return 32'(cmdw);
      2: return 32'd1;
      3: return 32'(argw);
      default: return 32'(2 + cmdw + argw);
    endcase
  endfunction

  typedef struct packed {
    logic [1:0]  s;
    logic [7:0]  after;
    logic [1:0]  lat;
    logic        bad;
    logic [31:0] code;
    logic [31:0] rarg;
    logic [4:0]  est;
    logic [31:0] earg;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'd1, 2'd0, 1'b0, 32'h0000_0001, 32'h1234_5678, 5'h00, 32'h1234_5678},
    '{2'd1, 8'd3, 2'd0, 1'b0, 32'h0000_0001, 32'hffff_fffe, 5'h00, 32'hffff_fffe},
    '{2'd2, 8'd2, 2'd2, 1'b0, 32'h8000_0004, 32'h0000_0005, 5'h04, 32'h0000_0005},
    '{2'd0, 8'd1, 2'd1, 1'b0, 32'h8000_0001, 32'h0000_0007, 5'h01, 32'h0000_0007},
    '{2'd1, 8'd1, 2'd0, 1'b0, 32'h8000_0002, 32'h0000_0009, 5'h02, 32'h0000_0009},
    '{2'd2, 8'd1, 2'd0, 1'b0, 32'h8000_0008, 32'h0000_000a, 5'h08, 32'h0000_000a},
    '{2'd0, 8'd1, 2'd0, 1'b0, 32'h8000_0000, 32'h0000_000b, 5'h08, 32'h0000_000b},
    '{2'd1, 8'd2, 2'd0, 1'b1, 32'h0000_0001, 32'h0000_00aa, 5'h04, 32'h0000_00aa},
    '{2'd2, 8'd1, 2'd0, 1'b1, 32'h8000_0002, 32'h0000_000c, 5'h04, 32'h0000_000c},
    '{2'd1, 8'd1, 2'd0, 1'b0, 32'h8000_0006, 32'h0000_000d, 5'h02, 32'h0000_000d},
    '{2'd0, 8'd0, 2'd1, 1'b0, 32'h0000_0001, 32'h0000_000e, 5'h10, 32'h0000_0000}
  };

  task automatic clear_stats();
    @(negedge clk); clr_stats = 1'b1;
    @(negedge clk); clr_stats = 1'b0;
  endtask

  task automatic launch(input logic [1:0] s);
    @(negedge clk); start = 1'b1; sel = s;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && status == 5'd0 && arg == 32'd0 && bus_req == 1'b0, "R1 reset outputs",
        {done, bus_req, status, arg[24:0]}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && status == 5'd0 && bus_req == 1'b0, "R1 after release", {27'd0, status}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      vec_t v = VECS[i];
      cfg_after = v.after; cfg_lat = v.lat; cfg_bad = v.bad; cfg_code = v.code; cfg_arg = v.rarg;
      clear_stats();
      launch(v.s);
      wait_done();
      for (int k = 0; k < 5; k++)
        chk(sent[k] == exp_word(int'(v.s), k), "R2 frame word", sent[k], exp_word(int'(v.s), k));
      chk(bell_val == 32'd1 && bell_cnt == 1, "R4 doorbell value", bell_val, 32'd1);
      chk(bell_pos == 5, "R4 doorbell after frame", 32'(bell_pos), 32'd5);
      if (v.est == 5'h10) tag = "R6 timeout";
      else if (v.bad) tag = "R3 checksum override";
      else if (v.est == 5'h00) tag = "R7 success";
      else tag = "R8 error map";
      chk(status == v.est, tag, {27'd0, status}, {27'd0, v.est});
      chk(arg == v.earg, tag, arg, v.earg);
      chk(host_wr == 1 && host_last == 32'd0, "R9 reply mailbox cleared", host_last, 32'd0);
      if (v.after == 8'd0) begin
        chk(polls == LIMIT, "R6 poll count", 32'(polls), 32'(LIMIT));
        chk(msg_rd == 0, "R6 no reply reads", 32'(msg_rd), 32'd0);
      end else begin
        chk(polls == int'(v.after), "R5 polls until nonzero", 32'(polls), 32'(v.after));
        chk(msg_rd == 5, "R7 reply words read", 32'(msg_rd), 32'd5);
      end
      if (polls >= 2)
        chk(last_t - prev_t == GAP + 2 + int'(v.lat), "R5 poll spacing",
            32'(last_t - prev_t), 32'(GAP + 2 + int'(v.lat)));
      @(negedge clk);
      chk(done == 1'b0, "R11 done pulse width", {31'd0, done}, 32'd0);
      chk(hold_err == 0, "R12 request held", 32'(hold_err), 32'd0);
    end

    // R10: select 3 rejected at once
    clear_stats();
    launch(2'd3);
    chk(done == 1'b1 && status == 5'b00010, "R10 reject", {26'd0, done, status}, {26'd0, 1'b1, 5'b00010});
    repeat (5) @(negedge clk);
    chk(acc_cnt == 0 && bus_req == 1'b0, "R10 no bus traffic", 32'(acc_cnt), 32'd0);

    // R11: start while busy ignored, results held
    cfg_after = 8'd2; cfg_lat = 2'd0; cfg_bad = 1'b0; cfg_code = 32'd1; cfg_arg = 32'h55;
    clear_stats();
    launch(2'd0);
    repeat (4) @(negedge clk);
    launch(2'd2);
    wait_done();
    chk(sent[1] == 32'd1 && sent[3] == 32'd1, "R11 busy start ignored", sent[3], 32'd1);
    chk(bell_cnt == 1, "R11 single doorbell", 32'(bell_cnt), 32'd1);
    repeat (20) @(negedge clk);
    chk(done_cnt == 1, "R11 single completion", 32'(done_cnt), 32'd1);
    chk(status == 5'd0 && arg == 32'h55, "R11 result held", arg, 32'h55);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule